// File: doc/BRIEF.md
# Asynchronous byte-wide SRAM controller

This block is a synchronous front end for a 128K x 8 asynchronous static RAM. A host issues single-byte reads or writes through a request port: it carries a direction flag, a 17-bit address and write data, and returns read data with a one-cycle acknowledge. The controller drives the RAM's active-low chip enable, output enable and write enable strobes, the address lines and a shared tri-state data bus.

Each access runs in phases. The address is registered first. The strobes assert one cycle later and stay low for a fixed number of clock cycles while the address holds. A read samples the bus at the end of its access window. A write keeps output enable high for its whole length, drives the bus only while write enable is low, and releases the bus one cycle before write enable rises. A recovery gap follows every write. The access window, the write pulse and the recovery gap are parameters counted in clock cycles. The host sees `rdy_o` low from the cycle an access is accepted until its acknowledge. Any request made while `rdy_o` is low is ignored.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_ni` is low and directly after reset: `mem_ce_no`, `mem_oe_no` and `mem_we_no` are 1, the controller does not drive `mem_dq_io`, `rdy_o` is 1 and `ack_o` is 0. Asserting `rst_ni` in the middle of an access returns the strobes to 1 at once.
- R2: A request is accepted at a rising clock edge where `req_i` and `rdy_o` are both 1. For a read (`we_i`=0), `mem_ce_no` and `mem_oe_no` are 0 and `mem_we_no` is 1 for exactly ACC_CYC cycles. The bus is sampled at the edge that ends that window. `ack_o` rises ACC_CYC+1 edges after the accept edge, with the sampled byte on `rdata_o`.
- R3: For a write (`we_i`=1), `mem_ce_no` and `mem_we_no` are 0 together for exactly WP_CYC cycles, and `mem_oe_no` stays 1 for the whole access. The RAM stores `wdata_i` at the accepted address. `ack_o` rises WP_CYC+WR_CYC+1 edges after the accept edge.
- R4: `mem_addr_o` takes the accepted address at the accept edge. The strobes assert one cycle later, and the address holds unchanged while `mem_ce_no` is 0.
- R5: The controller drives `mem_dq_io` only while `mem_we_no` and `mem_ce_no` are 0. It releases the bus one cycle before `mem_we_no` rises. The drive therefore lasts WP_CYC-1 cycles, and a WP_CYC below 2 is raised to 2.
- R6: After `mem_we_no` rises, it stays 1 for at least WR_CYC cycles before it falls again.
- R7: `ack_o` is a single-cycle pulse, one for each accepted access.
- R8: `rdy_o` is 0 from the accept edge until the cycle `ack_o` is 1. A request made while `rdy_o` is 0 starts no access, produces no acknowledge and changes no memory byte.
- R9: `rdata_o` holds the last byte read until the next read completes. Writes leave it unchanged.
- R10: All 17 address bits reach the RAM, so address 17'h00000 and address 17'h1FFFF hold distinct bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write data |
| rdy_o | output | 1 | Idle, can accept a request |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| mem_addr_o | output | 17 | RAM address lines |
| mem_ce_no | output | 1 | RAM chip enable, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_dq_io | inout | 8 | RAM data bus |

## Verification
The RAM model drives a garbage byte until the strobes have been low for ACC_CYC cycles, so a read that samples early returns a wrong value. The vectors write complementary and alternating bit patterns to the lowest and highest addresses and to addresses with alternating bits set, then read them back. An address bit that is dropped, a data bit that is stuck, or two locations that alias each other all show up as a read mismatch. Directed tests cover four cases: back-to-back writes, which exercise the recovery gap; a request held high while the controller is busy, which must be ignored; a write after a read, which must leave `rdata_o` as it was; and a reset in the middle of an access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV
  } state_e;
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (load_i)           cnt_o <= load_val_i;
    else if (cnt_o != '0)      cnt_o <= cnt_o - 1'b1;
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 3,
  parameter int WR_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             zero_i,
  output logic             rdy_o,
  output logic             accept_o,
  output logic             sample_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             ce_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             dq_drv_o,
  output logic             ack_o
);
  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  state_e state_q;

  assign rdy_o    = (state_q == ST_IDLE);
  assign accept_o = rdy_o && req_i;
  assign sample_o = (state_q == ST_RD_ACC) && zero_i;

  always_comb begin
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_RD_SETUP: begin load_o = 1'b1; load_val_o = ACC_LD; end
      ST_WR_SETUP: begin load_o = 1'b1; load_val_o = WP_LD;  end
      ST_WR_PULSE: if (zero_i) begin load_o = 1'b1; load_val_o = WR_LD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ce_no    <= 1'b1;
      oe_no    <= 1'b1;
      we_no    <= 1'b1;
      dq_drv_o <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      case (state_q)
        ST_IDLE:
          if (req_i) state_q <= we_i ? ST_WR_SETUP : ST_RD_SETUP;
        ST_RD_SETUP: begin
          ce_no   <= 1'b0;
          oe_no   <= 1'b0;
          state_q <= ST_RD_ACC;
        end
        ST_RD_ACC:
          if (zero_i) begin
            ce_no   <= 1'b1;
            oe_no   <= 1'b1;
            ack_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        ST_WR_SETUP: begin
          ce_no    <= 1'b0;
          we_no    <= 1'b0;
          dq_drv_o <= 1'b1;
          state_q  <= ST_WR_PULSE;
        end
        ST_WR_PULSE: begin
          // release bus one cycle ahead of write enable rising
          if (cnt_i == ONE) dq_drv_o <= 1'b0;
          if (zero_i) begin
            ce_no   <= 1'b1;
            we_no   <= 1'b1;
            state_q <= ST_WR_RECOV;
          end
        end
        ST_WR_RECOV:
          if (zero_i) begin
            ack_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl_dbus.sv
module sram_ctrl_dbus #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] dq_out_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      dq_out_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      dq_out_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (sample_i) rdata_o <= dq_in_i;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 3,
  parameter int WR_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  inout  wire  [DATA_W-1:0] mem_dq_io
);
  localparam int ACC_EFF = (ACC_CYC < 1) ? 1 : ACC_CYC;
  localparam int WP_EFF  = (WP_CYC  < 2) ? 2 : WP_CYC;
  localparam int WR_EFF  = (WR_CYC  < 1) ? 1 : WR_CYC;
  localparam int MAX_AW  = (ACC_EFF > WP_EFF) ? ACC_EFF : WP_EFF;
  localparam int MAX_CYC = (MAX_AW > WR_EFF) ? MAX_AW : WR_EFF;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, sample, load, zero, dq_drv;
  logic [CNT_W-1:0] load_val, cnt;
  logic [DATA_W-1:0] dq_out;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .zero_o(zero)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .ACC_CYC(ACC_EFF), .WP_CYC(WP_EFF), .WR_CYC(WR_EFF)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .cnt_i(cnt), .zero_i(zero), .rdy_o(rdy_o), .accept_o(accept),
    .sample_o(sample), .load_o(load), .load_val_o(load_val),
    .ce_no(mem_ce_no), .oe_no(mem_oe_no), .we_no(mem_we_no),
    .dq_drv_o(dq_drv), .ack_o(ack_o)
  );

  sram_ctrl_dbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dbus (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .addr_i(addr_i),
    .wdata_i(wdata_i), .sample_i(sample), .dq_in_i(mem_dq_io),
    .mem_addr_o(mem_addr_o), .dq_out_o(dq_out), .rdata_o(rdata_o)
  );

  assign mem_dq_io = dq_drv ? dq_out : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int WR_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dq_drv_i,
  input logic              ack_i,
  input logic              rdy_i
);
  logic [15:0] we_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     we_hi_cnt <= 16'hFFFF;
    else if (!we_ni)                 we_hi_cnt <= '0;
    else if (we_hi_cnt != 16'hFFFF)  we_hi_cnt <= we_hi_cnt + 1'b1;
  end

  // R3
  oe_off_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_ni && !we_ni));

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && $past(!ce_ni)) |-> (addr_i == $past(addr_i)));

  // R4
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_ni) |-> $stable(addr_i));

  // R5
  drive_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_drv_i |-> (!we_ni && !ce_ni));

  // R5
  early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_ni) |-> !$past(dq_drv_i));

  // R6
  we_recovery_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_ni) |-> (we_hi_cnt >= 16'(WR_CYC)));

  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i);

  // R8
  busy_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |-> !rdy_i);

  // R2
  oe_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> !ce_ni);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(mem_ce_no), .oe_ni(mem_oe_no),
  .we_ni(mem_we_no), .addr_i(mem_addr_o), .dq_drv_i(dq_drv),
  .ack_i(ack_o), .rdy_i(rdy_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
  localparam int ACC = 3;
  localparam int WP  = 3;
  localparam int WR  = 2;
  localparam int NV  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rdy, ack;
  logic [7:0]  rdata;
  logic [16:0] maddr;
  logic        ce_n, oe_n, we_n;
  wire  [7:0]  dq;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sram_ctrl #(.ACC_CYC(ACC), .WP_CYC(WP), .WR_CYC(WR)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdy_o(rdy), .ack_o(ack), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_ce_no(ce_n), .mem_oe_no(oe_n),
    .mem_we_no(we_n), .mem_dq_io(dq)
  );

  // behavioural RAM
  logic [7:0]  mem_m [int unsigned];
  logic [7:0]  m_dout;
  logic        m_drv;
  int          acc_cnt = 0, hi_cnt = 1000, viol = 0;
  logic        win_q = 1'b0, ce_lo_q = 1'b0, we_q = 1'b1;
  logic [16:0] waddr, prev_addr;
  logic [7:0]  wlat;

  assign m_drv = !ce_n && !oe_n && we_n;
  assign dq = m_drv ? m_dout : 8'bz;

  function automatic logic [7:0] rd_mem(input logic [16:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      acc_cnt = 0; win_q = 1'b0; ce_lo_q = 1'b0; we_q = 1'b1;
    end else begin
      if (!oe_n && !we_n) viol++;
      if (!ce_n && ce_lo_q && maddr != prev_addr) viol++;
      acc_cnt = (!ce_n && !oe_n) ? acc_cnt + 1 : 0;
      m_dout  = (acc_cnt >= ACC) ? rd_mem(maddr) : 8'hEE;
      if (!ce_n && !we_n) begin
        if (!win_q) begin waddr = maddr; wlat = dq; end
      end else if (win_q) begin
        mem_m[int'(waddr)] = wlat;
      end
      if (!we_n && we_q && hi_cnt < WR) viol++;
      hi_cnt  = we_n ? hi_cnt + 1 : 0;
      win_q   = !ce_n && !we_n;
      ce_lo_q = !ce_n;
      we_q    = we_n;
      prev_addr = maddr;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    int lat = 0, ce_lo = 0, oe_lo = 0, we_lo = 0, drv = 0, late_drv = 0;
    bit prev_we_lo = 0, prev_match = 0, match;
    @(negedge clk);
    chk(rdy == 1'b1, "R8", "rdy before request", rdy, 1);
    req = 1'b1; we = w; addr = a; wdata = d;
    do begin
      @(negedge clk);
      if (lat == 0) req = 1'b0;
      lat++;
      if (lat == 1) begin
        chk(maddr == a, "R4", "address at accept", maddr, a);
        chk(ce_n == 1'b1, "R4", "strobe one cycle after address", ce_n, 1);
        chk(rdy == 1'b0, "R8", "rdy while busy", rdy, 0);
      end
      if (!ce_n) ce_lo++;
      if (!oe_n) oe_lo++;
      match = w && (dq === d);
      if (!we_n) begin we_lo++; if (match) drv++; end
      else if (match) late_drv++;
      if (we_n && prev_we_lo && prev_match) late_drv++;
      prev_we_lo = !we_n; prev_match = match;
    end while (!ack && lat < 200);
    rd = rdata;
    if (w) begin
      chk(lat == WP + WR + 2, "R3", "write ack latency", lat, WP + WR + 2);
      chk(ce_lo == WP && we_lo == WP, "R3", "ce/we low cycles", we_lo, WP);
      chk(oe_lo == 0, "R3", "oe low during write", oe_lo, 0);
      chk(drv == WP - 1, "R5", "bus drive cycles", drv, WP - 1);
      chk(late_drv == 0, "R5", "drive at or after we rise", late_drv, 0);
    end else begin
      chk(lat == ACC + 2, "R2", "read ack latency", lat, ACC + 2);
      chk(ce_lo == ACC && oe_lo == ACC && we_lo == 0, "R2", "read strobe cycles",
          oe_lo, ACC);
    end
  endtask

  // {we, addr, wdata, expected read}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
    {1'b1, 17'h0AAAA, 8'h33, 8'h00},
    {1'b1, 17'h15555, 8'hCC, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
    {1'b0, 17'h0AAAA, 8'h00, 8'h33},
    {1'b0, 17'h15555, 8'h00, 8'hCC},
    {1'b1, 17'h00000, 8'hFF, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hFF}
  };

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd, keep;
    repeat (3) @(negedge clk);
    // R1 in reset
    chk(ce_n && oe_n && we_n, "R1", "strobes in reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(rdy == 1'b1 && ack == 1'b0, "R1", "rdy/ack in reset", {rdy, ack}, 2'b10);
    chk(dq !== 8'hA5, "R1", "bus undriven in reset", dq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && rdy && !ack, "R1", "state after reset",
        {ce_n, oe_n, we_n, rdy, ack}, 5'b11110);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][33], VEC[i][32:16], VEC[i][15:8], rd);
      if (!VEC[i][33])
        chk(rd == VEC[i][7:0], (i == 5) ? "R10" : "R2", "read data", rd, VEC[i][7:0]);
      @(negedge clk);
      chk(ack == 1'b0, "R7", "ack single cycle", ack, 0);
    end

    // R9: write keeps rdata_o
    access(1'b0, 17'h1FFFF, 8'h00, keep);
    access(1'b1, 17'h00123, 8'h9C, rd);
    chk(rdata == keep, "R9", "rdata after write", rdata, keep);

    // R6: back-to-back writes, recovery judged by RAM model
    access(1'b1, 17'h00200, 8'h11, rd);
    access(1'b1, 17'h00201, 8'h22, rd);
    access(1'b0, 17'h00200, 8'h00, rd);
    chk(rd == 8'h11, "R6", "first of back-to-back writes", rd, 8'h11);

    // R8: request while busy is ignored
    access(1'b1, 17'h00300, 8'h44, rd);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 17'h00301; wdata = 8'h66;
    @(negedge clk);
    req = 1'b0; addr = 17'h00301; wdata = 8'h77; we = 1'b1;
    // busy write into 00301 then a held-off request to 00300
    begin
      int acks = 0;
      for (int c = 0; c < WP + WR + 1; c++) begin
        @(negedge clk);
        if (c == 0) begin req = 1'b1; addr = 17'h00300; wdata = 8'h99; end
        if (c == 2) req = 1'b0;
        if (ack) acks++;
      end
      for (int c = 0; c < 6; c++) begin @(negedge clk); if (ack) acks++; end
      chk(acks == 1, "R8", "acks for one accepted access", acks, 1);
    end
    access(1'b0, 17'h00300, 8'h00, rd);
    chk(rd == 8'h44, "R8", "byte untouched by held-off request", rd, 8'h44);
    access(1'b0, 17'h00301, 8'h00, rd);
    chk(rd == 8'h66, "R8", "accepted write landed", rd, 8'h66);

    // R1: reset mid access
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 17'h00000;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk(ce_n == 1'b0, "R1", "read in progress", ce_n, 0);
    rst_n = 1'b0;
    #1;
    chk(ce_n && oe_n && we_n && rdy, "R1", "async reset mid access",
        {ce_n, oe_n, we_n, rdy}, 4'b1111);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(viol == 0, "R4", "RAM model ordering violations (R6 R3)", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule